// File: doc/BRIEF.md
# Serial Control Port with Frame-Routed Registers

This block is a serial slave that takes 16-bit instruction frames over a four-wire link: a serial clock, an active-low chip enable, a data-in line and a data-out line. Each complete frame is stored in one of two parallel control registers. The last bit of the frame picks the register: the settings register takes the frame when that bit is 1, and the main register takes it when that bit is 0. A one-cycle write strobe marks each update, so downstream logic can pick up the new setting.

The block also returns a 16-bit status word on the data-out line. While chip enable is high, every rising clock edge reloads the output shifter. The word loaded is either the main readback word or the information word, and a request bit in the most recent main frame chooses between them. The whole block runs in the serial clock domain, and the serial clock is expected to run continuously.

Top module: `sfr_top`

## Requirements
- R1: Data in is sampled on each rising clock edge while chip enable is low, most significant bit first. The 16 sampled bits form the frame, and the frame takes effect on the 16th rising edge after chip enable falls.
- R2: When frame bit 0 is 1, the frame is written to the settings register. When frame bit 0 is 0, the frame is written to the main register.
- R3: A completed frame leaves the register it is not routed to unchanged.
- R4: If chip enable rises before the 16th edge, the partial frame is dropped and neither register changes.
- R5: Rising edges after the 16th while chip enable is still low write to neither register.
- R6: Each rising edge with chip enable high loads the selected status word into the output shifter, and data out shows its bit 15. Each rising edge with chip enable low moves the next lower bit onto data out, so after k such edges data out shows bit 15-k.
- R7: Bit 1 of the most recent main frame selects the status word: 0 selects the main readback word and 1 selects the information word. Settings frames do not change this selection.
- R8: An asynchronous active-low reset clears both registers, both strobes and the bit counter, and sets the selection to the main readback word.
- R9: The strobe of the written register is high for exactly the one clock cycle that follows the 16th edge. The other strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low frame enable |
| mosi | input | 1 | Serial data in, most significant bit first |
| miso | output | 1 | Serial data out, most significant bit first |
| normal_rb_i | input | 16 | Main readback status word |
| info_i | input | 16 | Information status word |
| normal_reg_o | output | 16 | Main control register |
| config_reg_o | output | 16 | Settings control register |
| normal_wr_o | output | 1 | One-cycle strobe after a main register write |
| config_wr_o | output | 1 | One-cycle strobe after a settings register write |

## Verification
The bench builds the block with its default values: a 16-bit frame, the selector at bit 0 and the request at bit 1. With these values every data-out bit of every frame can be checked against a word the bench predicts. Random frames, with random lengths that include short frames and frames with extra clocks, are mixed with directed cases. The directed cases cover the first readback after reset, switching between the two status words, and a settings frame that arrives between main frames.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic {RB_NORMAL = 1'b0, RB_INFO = 1'b1} rb_src_e;

  // counter width able to hold the value w (saturating edge count)
  function automatic int cnt_bits(input int w);
    return $clog2(w + 1);
  endfunction

  // pick the status word for the output shifter
  function automatic logic [63:0] status_pick(input rb_src_e sel,
                                              input logic [63:0] nrb,
                                              input logic [63:0] inf);
    return (sel == RB_INFO) ? inf : nrb;
  endfunction
endpackage

// File: rtl/sfr_rx.sv
module sfr_rx #(
  parameter int W  = 16,
  parameter int CW = sfr_pkg::cnt_bits(W)
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         mosi,
  output logic         frame_done,
  output logic [W-1:0] frame_word
);
  logic [W-2:0] sh_q;
  logic [CW-1:0] bit_cnt;

  assign frame_word = {sh_q, mosi};
  assign frame_done = !ce_n && (bit_cnt == CW'(W - 1));

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bit_cnt <= '0;
    end else if (ce_n) begin
      bit_cnt <= '0;
    end else begin
      sh_q <= frame_word[W-2:0];
      if (bit_cnt != CW'(W)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R4
  cnt_clear_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    ce_n |=> (bit_cnt == '0));

  // R5
  cnt_sat_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    bit_cnt <= CW'(W));
endmodule

// File: rtl/sfr_route.sv
module sfr_route #(
  parameter int W        = 16,
  parameter int SEL_POS  = 0,
  parameter int IREQ_POS = 1
) (
  input  logic            sclk,
  input  logic            rst_n,
  input  logic            frame_done,
  input  logic [W-1:0]    frame_word,
  output logic [W-1:0]    normal_q,
  output logic [W-1:0]    config_q,
  output logic            normal_wr,
  output logic            config_wr,
  output sfr_pkg::rb_src_e rb_sel
);
  import sfr_pkg::*;

  logic to_config, to_normal;
  assign to_config = frame_done &&  frame_word[SEL_POS];
  assign to_normal = frame_done && !frame_word[SEL_POS];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      normal_q  <= '0;
      config_q  <= '0;
      normal_wr <= 1'b0;
      config_wr <= 1'b0;
      rb_sel    <= RB_NORMAL;
    end else begin
      normal_wr <= to_normal;
      config_wr <= to_config;
      if (to_config) config_q <= frame_word;
      if (to_normal) begin
        normal_q <= frame_word;
        rb_sel   <= frame_word[IREQ_POS] ? RB_INFO : RB_NORMAL;
      end
    end
  end

  // R9
  strobe_onehot_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    $onehot0({normal_wr, config_wr}));

  // R3
  cfg_untouched_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    normal_wr |-> $stable(config_q));

  // R7
  sel_change_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (rb_sel != $past(rb_sel)) |-> normal_wr);
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx #(
  parameter int W = 16
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  sfr_pkg::rb_src_e rb_sel,
  input  logic [W-1:0]     normal_rb,
  input  logic [W-1:0]     info,
  output logic             miso
);
  import sfr_pkg::*;

  logic [W-1:0] sh_q;
  logic [63:0]  picked;

  assign picked = status_pick(rb_sel, 64'(normal_rb), 64'(info));
  assign miso   = sh_q[W-1];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (ce_n) sh_q <= picked[W-1:0];
    else           sh_q <= {sh_q[W-2:0], 1'b0};
  end

  // R6
  shift_zero_fill_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> (sh_q[0] == 1'b0));
endmodule

// File: rtl/sfr_top.sv
module sfr_top #(
  parameter int W        = 16,
  parameter int SEL_POS  = 0,
  parameter int IREQ_POS = 1
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         mosi,
  output logic         miso,
  input  logic [W-1:0] normal_rb_i,
  input  logic [W-1:0] info_i,
  output logic [W-1:0] normal_reg_o,
  output logic [W-1:0] config_reg_o,
  output logic         normal_wr_o,
  output logic         config_wr_o
);
  logic             frame_done;
  logic [W-1:0]     frame_word;
  sfr_pkg::rb_src_e rb_sel;

  sfr_rx #(.W(W)) u_rx (
    .sclk(sclk), .rst_n(rst_n), .ce_n(ce_n), .mosi(mosi),
    .frame_done(frame_done), .frame_word(frame_word)
  );

  sfr_route #(.W(W), .SEL_POS(SEL_POS), .IREQ_POS(IREQ_POS)) u_route (
    .sclk(sclk), .rst_n(rst_n), .frame_done(frame_done), .frame_word(frame_word),
    .normal_q(normal_reg_o), .config_q(config_reg_o),
    .normal_wr(normal_wr_o), .config_wr(config_wr_o), .rb_sel(rb_sel)
  );

  sfr_tx #(.W(W)) u_tx (
    .sclk(sclk), .rst_n(rst_n), .ce_n(ce_n), .rb_sel(rb_sel),
    .normal_rb(normal_rb_i), .info(info_i), .miso(miso)
  );

  // R2
  cfg_route_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    config_wr_o |-> config_reg_o[SEL_POS]);
endmodule

// File: tb/sfr_top_tb.sv
module sfr_top_tb;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [15:0] normal_rb_i = '0;
  logic [15:0] info_i = '0;
  logic [15:0] normal_reg_o, config_reg_o;
  logic        normal_wr_o, config_wr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] m_norm = '0, m_cfg = '0;
  logic        m_ireq = 1'b0;

  sfr_top u_dut (
    .sclk(sclk), .rst_n(rst_n), .ce_n(ce_n), .mosi(mosi), .miso(miso),
    .normal_rb_i(normal_rb_i), .info_i(info_i),
    .normal_reg_o(normal_reg_o), .config_reg_o(config_reg_o),
    .normal_wr_o(normal_wr_o), .config_wr_o(config_wr_o)
  );

  always #4 sclk = ~sclk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input logic ireq, input logic [15:0] nrb,
                                             input logic [15:0] inf);
    if (ireq) return inf;
    return nrb;
  endfunction

  // one frame of n edges with chip enable low; status inputs set first
  task automatic frame(input logic [15:0] w, input int n,
                       input logic [15:0] nrb, input logic [15:0] inf);
    logic [15:0] st;
    @(negedge sclk);
    ce_n = 1'b1; mosi = 1'b0; normal_rb_i = nrb; info_i = inf;
    @(negedge sclk);
    st = exp_status(m_ireq, nrb, inf);
    ce_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      mosi = (k < 16) ? w[15-k] : 1'($urandom);
      if (k < 16) chk("R6 miso bit", 32'(miso), 32'(st[15-k]));
      @(negedge sclk);
    end
    if (n >= 16) begin
      if (w[0]) m_cfg = w;
      else begin m_norm = w; m_ireq = w[1]; end
    end
    if (n == 16) begin
      chk("R9 normal strobe", 32'(normal_wr_o), 32'(!w[0]));
      chk("R9 config strobe", 32'(config_wr_o), 32'(w[0]));
    end else begin
      chk("R4 R5 no strobe", 32'({normal_wr_o, config_wr_o}), 32'd0);
    end
    chk("R1 R2 R3 R4 R5 normal reg", 32'(normal_reg_o), 32'(m_norm));
    chk("R1 R2 R3 R4 R5 config reg", 32'(config_reg_o), 32'(m_cfg));
    ce_n = 1'b1; mosi = 1'b0;
    @(negedge sclk);
    chk("R9 strobe drops", 32'({normal_wr_o, config_wr_o}), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge sclk);
    // R8 reset state
    chk("R8 normal reg", 32'(normal_reg_o), 32'd0);
    chk("R8 config reg", 32'(config_reg_o), 32'd0);
    chk("R8 strobes", 32'({normal_wr_o, config_wr_o}), 32'd0);
    rst_n = 1'b1;

    // R7 R8: first readback selects main word; main frame requests info
    frame(16'hA5A2, 16, 16'h1234, 16'hBEEF);
    // R7: readback now info; settings frame keeps the selection
    frame(16'h3C3D, 16, 16'h5555, 16'hC0DE);
    frame(16'h0F00, 16, 16'h9ABC, 16'h7E57);
    // R7: request cleared, next readback is main word
    frame(16'hFFFC, 16, 16'h8001, 16'h0110);
    // R4 partial frames of various lengths
    frame(16'h1111, 10, 16'h2222, 16'h3333);
    frame(16'h4445, 15, 16'h6666, 16'h7777);
    frame(16'h8888, 1, 16'h9999, 16'hAAAA);
    // R5 extra edges after the 16th
    frame(16'h5A5B, 21, 16'hCCCC, 16'hDDDD);
    frame(16'h0002, 17, 16'hEEEE, 16'h1357);
    frame(16'hFFFF, 16, 16'h2468, 16'hACE0);

    for (int i = 0; i < 80; i++) begin
      int n;
      n = ($urandom % 4 == 0) ? 1 + int'($urandom % 22) : 16;
      frame(16'($urandom), n, 16'($urandom), 16'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule